// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Word Data Memory

This block is the data memory beside the load/store stage of a 32-bit processor core. The stage hands it a base register value and the signed 16-bit displacement taken from the instruction. The memory forms the effective address from these two values. It then either returns the word held there or writes the register word into it. Every address names a single byte, and a word spans four neighbouring bytes. The byte at the lowest of those four addresses is the most significant byte of the word.

Only whole-word accesses are served, and they must fall on a four-byte boundary. When an access is misaligned, the block raises a flag in the same cycle and blocks any write. Reads come straight out of the storage array with no register in the path. Writes take effect on the rising clock edge. The storage is small, 256 bytes by default. Address bits above the array size take no part in selecting a byte, so the address space repeats every `MEM_BYTES` bytes.

Top module: `be_data_mem`

## Requirements
- R1: The effective address is `base_i` plus `offset_i` sign-extended to 32 bits, so offsets with bit 15 set reach addresses below the base.
- R2: While `load_i` is high and the effective address is word aligned, `rdata_o` shows the stored word in the same cycle. Bits 31..24 hold the byte at the effective address, and bits 7..0 hold the byte at the effective address plus 3.
- R3: A store (`store_i` high) to an aligned effective address writes `wdata_i` on the rising clock edge. Bits 31..24 go to the lowest byte address. A load of that address in any later cycle returns the word.
- R4: `misalign_o` is high exactly when `load_i` or `store_i` is high and bits 1..0 of the effective address are not both zero. It is low when neither strobe is high.
- R5: A store to a misaligned effective address changes no byte of the memory.
- R6: Only bits 7..0 of the effective address (at the default of 256 bytes) select a byte. Two addresses that differ only above that range reach the same word.
- R7: While `rst_n` is low, every byte is cleared to zero. After reset, a load of any aligned address returns zero until a store writes to it.
- R8: `rdata_o` is zero whenever `load_i` is low or the access is misaligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the storage |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement from the instruction |
| wdata_i | input | 32 | Word to be stored |
| load_i | input | 1 | Load request |
| store_i | input | 1 | Store request |
| rdata_o | output | 32 | Loaded word, zero when no aligned load is requested |
| misalign_o | output | 1 | Effective address of the current access is not word aligned |

## Verification
The assertions assume that the address, offset and strobe inputs hold known values from the first clock edge after reset. The store-then-load property only checks a load that follows a store with the base and offset held steady and the store strobe dropped. The bench drives every input at zero from time zero and changes inputs only on the falling edge. Its directed sequences include store-followed-by-load pairs at identical base and offset, which gives that property real cases to examine.

// File: rtl/be_mem_pkg.sv
// Package: shared constants and helpers for the big-endian data memory.
// Assumes a word is a whole number of bytes.
package be_mem_pkg;
    localparam int BYTE_W = 8;

    // Sign-extend a displacement of width OW into a value of width AW.
    function automatic logic [63:0] sext64(input logic [63:0] val, input int ow);
        logic [63:0] res;
        res = val;
        for (int b = 0; b < 64; b++) begin
            if (b >= ow) res[b] = val[ow-1];
        end
        return res;
    endfunction
endpackage

// File: rtl/be_ea_unit.sv
// Module: effective-address unit. Adds the sign-extended displacement to the
// base value and reports whether the result falls on a word boundary.
// Assumes OFF_W <= ADDR_W <= 64.
module be_ea_unit #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LSB_W  = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              aligned_o
);
    import be_mem_pkg::*;

    logic [63:0] off_ext;

    // Widen the displacement, copying its sign bit upward.
    always_comb begin
        off_ext = sext64({{(64-OFF_W){1'b0}}, offset_i}, OFF_W);
    end

    // Form the effective address and its alignment.
    always_comb begin
        ea_o      = base_i + off_ext[ADDR_W-1:0];
        aligned_o = (ea_o[LSB_W-1:0] == '0);
    end
endmodule

// File: rtl/be_lane_bank.sv
// Module: one byte lane of the word memory. Holds the byte that sits at
// offset LANE inside every word. Synchronous clear, synchronous write,
// combinational read. Assumes the caller gives a valid word index.
module be_lane_bank #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             we_i,
    input  logic [7:0]       wbyte_i,
    output logic [7:0]       rbyte_o
);
    logic [7:0] cells [DEPTH];

    // Clear on reset, otherwise write the addressed cell when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we_i) begin
            cells[idx_i] <= wbyte_i;
        end
    end

    // Present the addressed cell without a register.
    always_comb begin
        rbyte_o = cells[idx_i];
    end
endmodule

// File: rtl/be_data_mem.sv
// Module: big-endian byte-addressed data memory serving aligned word loads
// and stores. Lane k holds the byte at word offset k and maps to the word
// bits starting from the top (lane 0 -> most significant byte). Address
// bits above the array size are dropped, so the space wraps.
// Assumes MEM_BYTES is a power of two and a multiple of the word size.
module be_data_mem #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int OFF_W     = 16,
    parameter int MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    input  logic              store_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              misalign_o
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int LSB_W      = $clog2(WORD_BYTES);
    localparam int DEPTH      = MEM_BYTES / WORD_BYTES;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int LOW_W      = LSB_W + IDX_W;

    logic [ADDR_W-1:0] ea;
    logic              aligned;
    logic [IDX_W-1:0]  word_idx;
    logic              wr_en;
    logic [DATA_W-1:0] word_rd;
    logic              unused_hi;

    be_ea_unit #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LSB_W  (LSB_W)
    ) u_ea (
        .base_i    (base_i),
        .offset_i  (offset_i),
        .ea_o      (ea),
        .aligned_o (aligned)
    );

    // Pick the word index and gate the write on alignment.
    always_comb begin
        word_idx  = ea[LSB_W +: IDX_W];
        wr_en     = store_i && aligned;
        unused_hi = ^ea[ADDR_W-1:LOW_W];
    end

    genvar lane;
    generate
        for (lane = 0; lane < WORD_BYTES; lane++) begin : g_lane
            localparam int TOP = DATA_W - 1 - 8 * lane;
            be_lane_bank #(
                .DEPTH (DEPTH),
                .IDX_W (IDX_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .idx_i   (word_idx),
                .we_i    (wr_en),
                .wbyte_i (wdata_i[TOP -: 8]),
                .rbyte_o (word_rd[TOP -: 8])
            );
        end
    endgenerate

    // Drive the read word and the alignment error flag.
    always_comb begin
        rdata_o    = (load_i && aligned) ? word_rd : '0;
        misalign_o = (load_i || store_i) && !aligned;
    end
endmodule

// File: rtl/be_data_mem_chk.sv
// Module: checker for be_data_mem, attached by bind. Observes ports only.
module be_data_mem_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_i,
    input logic [OFF_W-1:0]  offset_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              load_i,
    input logic              store_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              misalign_o
);
    logic [1:0] lo_sum;
    assign lo_sum = base_i[1:0] + offset_i[1:0];

    a_r4_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o == ((load_i || store_i) && (lo_sum != 2'b00)));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || store_i) |-> !misalign_o);

    a_r8_no_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |-> (rdata_o == '0));

    a_r8_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (rdata_o == '0));

    a_r3_store_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !load_i && !misalign_o) |=>
            ((load_i && !store_i && $stable(base_i) && $stable(offset_i))
                |-> (rdata_o == $past(wdata_i))));
endmodule

bind be_data_mem be_data_mem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_i     (base_i),
    .offset_i   (offset_i),
    .wdata_i    (wdata_i),
    .load_i     (load_i),
    .store_i    (store_i),
    .rdata_o    (rdata_o),
    .misalign_o (misalign_o)
);

// File: tb/be_data_mem_bench.sv
module be_data_mem_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEMB       = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] offset_i = '0;
    logic [31:0] wdata_i = '0;
    logic        load_i = 1'b0;
    logic        store_i = 1'b0;
    logic [31:0] rdata_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    byte unsigned model [MEMB];

    be_data_mem u_be_data_mem (
        .clk (clk), .rst_n (rst_n), .base_i (base_i), .offset_i (offset_i),
        .wdata_i (wdata_i), .load_i (load_i), .store_i (store_i),
        .rdata_o (rdata_o), .misalign_o (misalign_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] o);
        int signed so;
        so = $signed(o);
        return b + so;
    endfunction

    task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, compare against the model, then advance.
    task automatic step(input logic [31:0] b, input logic [15:0] o, input logic [31:0] wd,
                        input logic ld, input logic st, input string req);
        logic [31:0] ea;
        logic [31:0] exp_rd;
        logic        exp_mis;
        int          ix;
        base_i = b; offset_i = o; wdata_i = wd; load_i = ld; store_i = st;
        #(CLK_PERIOD/4);
        ea      = ea_of(b, o);
        ix      = int'(ea[7:0]);
        exp_mis = (ld || st) && (ea[1:0] != 2'b00);
        exp_rd  = (ld && ea[1:0] == 2'b00) ?
                  {model[ix], model[ix+1], model[ix+2], model[ix+3]} : 32'h0;
        compare({req, " rdata"}, rdata_o, exp_rd);
        compare({req, " misalign"}, {31'b0, misalign_o}, {31'b0, exp_mis});
        if (st && ea[1:0] == 2'b00 && rst_n) begin
            model[ix]   = wd[31:24];
            model[ix+1] = wd[23:16];
            model[ix+2] = wd[15:8];
            model[ix+3] = wd[7:0];
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] lfsr;
        for (int i = 0; i < MEMB; i++) model[i] = 8'h00;
        @(negedge clk);
        // R7: storage cleared while reset held; store during reset ignored
        step(32'h0, 16'h0, 32'hDEAD_BEEF, 1'b0, 1'b1, "R7 reset");
        step(32'h0, 16'h0, 32'h0, 1'b1, 1'b0, "R7 reset");
        rst_n = 1'b1;
        step(32'h0000_0040, 16'h0, 32'h0, 1'b1, 1'b0, "R7 zero after reset");
        step(32'h0, 16'h0, 32'h0, 1'b0, 1'b0, "R4 idle");
        // R3/R2: aligned store then same-address load; byte order fixed MSB first
        step(32'h0000_0010, 16'h0000, 32'h1122_3344, 1'b0, 1'b1, "R3 store");
        step(32'h0000_0010, 16'h0000, 32'h0, 1'b1, 1'b0, "R2 load");
        // R1: negative offset reaches the same word from above
        step(32'h0000_0020, 16'hFFF0, 32'h0, 1'b1, 1'b0, "R1 negative offset");
        step(32'h0000_0000, 16'h0024, 32'hA5A5_5A5A, 1'b0, 1'b1, "R1 positive offset");
        step(32'h0000_0030, 16'hFFF4, 32'h0, 1'b1, 1'b0, "R1 readback");
        // R4/R5: misaligned store flags and leaves the word untouched
        step(32'h0000_0011, 16'h0000, 32'hFFFF_FFFF, 1'b0, 1'b1, "R5 misaligned store");
        step(32'h0000_0012, 16'h0001, 32'hFFFF_FFFF, 1'b0, 1'b1, "R5 misaligned store");
        step(32'h0000_0010, 16'h0000, 32'h0, 1'b1, 1'b0, "R5 unchanged");
        step(32'h0000_0013, 16'h0000, 32'h0, 1'b1, 1'b0, "R8 misaligned load");
        step(32'h0000_0010, 16'h0002, 32'h0, 1'b1, 1'b0, "R4 offset misaligns");
        // R6: high address bits ignored, wrap past top
        step(32'h1234_5600, 16'h00FC, 32'hCAFE_F00D, 1'b0, 1'b1, "R6 store near top");
        step(32'h0000_00FC, 16'h0000, 32'h0, 1'b1, 1'b0, "R6 alias low");
        step(32'h0000_0100, 16'h0000, 32'h0BAD_C0DE, 1'b0, 1'b1, "R6 wrap store");
        step(32'h0000_0000, 16'h0000, 32'h0, 1'b1, 1'b0, "R6 wrap load");
        step(32'hFFFF_FFF0, 16'h0010, 32'h0, 1'b1, 1'b0, "R6 carry wrap");
        // R8: store with load low keeps rdata zero
        step(32'h0000_0080, 16'h0, 32'h7777_8888, 1'b0, 1'b1, "R8 no load");
        step(32'h0000_0080, 16'h0, 32'h0, 1'b1, 1'b0, "R3 load 80");
        // Mixed pseudo-random traffic (R1 R2 R3 R4 R5 R8)
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] b;
            logic [15:0] o;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = {lfsr[31:24], 16'h0, lfsr[7:0]};
            o = (lfsr[10]) ? {12'hFFF, lfsr[15:12]} : {8'h0, lfsr[23:16]};
            if (lfsr[9]) begin
                b[1:0] = 2'b00;
                o[1:0] = 2'b00;
            end
            step(b, o, lfsr ^ 32'h5A5A_A5A5, lfsr[3], lfsr[4] && !lfsr[3], "R1 R3 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule